// File: doc/BRIEF.md
# Daisy-Chain Status Poll Responder

This block is the per-device part of a shared status chain. Every device in a stack has one copy. During a status poll each copy drives the serial line toward the device below. A device that is busy, for example converting or holding a pending interrupt, pulls its line low. An idle device that is not the top of the stack passes on whatever arrives from the device above. The topmost idle device is the source of the "all clear" signal. In level mode it holds the line high. In toggle mode it produces a 1 kHz square wave, so that a broken link shows up as a stuck line rather than a false "idle".

A 1 kHz timebase comes from a prescaler. The prescaler's divide ratio is computed from a clock-frequency parameter, and it restarts every time a poll begins. Outside the poll phase the responder releases the line and lowers a separate output-enable. The master ends a poll by raising its chip-select, which drops the poll-active qualifier.

Top module: `chain_poll_responder`

## Requirements
- R1: `level_mode` = 1 selects level mode and `level_mode` = 0 selects toggle mode. This bit affects only what an idle top-of-stack device sends.
- R2: While `poll_active` = 1 and `busy_local` = 1, `sdo_out` is 0 in the same cycle, in both modes and at any stack position.
- R3: While `poll_active` = 1, `busy_local` = 0 and `top_strap` = 0, `sdo_out` equals `upstream_in` combinationally.
- R4: While `poll_active` = 1, `busy_local` = 0, `top_strap` = 1 and `level_mode` = 1, `sdo_out` is held at 1.
- R5: While `poll_active` = 1, `busy_local` = 0, `top_strap` = 1 and `level_mode` = 0, `sdo_out` is a square wave with half period H = CLK_HZ/2000 clock cycles. It is 1 right after the poll starts and changes value on every H-th rising clock edge counted from the first edge at which `poll_active` is 1.
- R6: The toggle prescaler and the square-wave phase restart whenever `poll_active` rises, whatever phase the previous poll ended in.
- R7: While `poll_active` = 0, `sdo_oe` is 0 and `sdo_out` is 1, whatever the other inputs are. While `poll_active` = 1, `sdo_oe` is 1.
- R8: In a chain, the bottom line is 0 whenever any device is busy. Otherwise it is 1 in level mode, or the top device's square wave in toggle mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock of frequency CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_active | input | 1 | High during the status-poll phase |
| busy_local | input | 1 | Local busy or interrupt condition |
| top_strap | input | 1 | High on the top device of the stack |
| level_mode | input | 1 | 1 = level mode, 0 = toggle mode |
| upstream_in | input | 1 | Line from the device above |
| sdo_out | output | 1 | Line toward the device below |
| sdo_oe | output | 1 | High while the responder drives the line |

## Verification
On every cycle, the assertions check the forcing rules for a busy device, the forwarding rule, the level-mode high, and the released state outside a poll. They also check that the phase bit changes exactly on prescaler ticks and that every poll starts from a cleared counter and a high phase. Only the bench's scenarios can show the actual half-period length, the restart after a poll that ended mid-phase, and what the bottom of a three-device chain reads for every pattern of busy devices in both modes.

// File: rtl/poll_pkg.sv
package poll_pkg;

  // Half period of a 1 kHz square wave, in clock cycles (never below 1).
  function automatic int unsigned half_period(input int unsigned clk_hz);
    int unsigned h;
    h = clk_hz / 2000;
    return (h < 1) ? 1 : h;
  endfunction

  // Counter width able to hold 0 .. half-1.
  function automatic int unsigned count_width(input int unsigned half);
    return (half < 2) ? 1 : $clog2(half);
  endfunction

  // What an idle device sends: pass-through, high, or the toggle phase.
  function automatic logic idle_value(input logic is_top, input logic lvl,
                                      input logic upstream, input logic phase);
    if (!is_top) return upstream;
    return lvl ? 1'b1 : phase;
  endfunction

endpackage

// File: rtl/poll_prescaler.sv
module poll_prescaler #(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  import poll_pkg::*;

  localparam int unsigned HALF = half_period(CLK_HZ);
  localparam int unsigned CW   = count_width(HALF);
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  assign tick = run && (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (!run)   cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // R6: every poll begins from a cleared prescaler
  assert_restart_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (cnt_q == '0));

  // R5: the counter never passes the half-period limit
  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

endmodule

// File: rtl/poll_phase.sv
module poll_phase (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  output logic phase
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     phase <= 1'b1;
    else if (!run)  phase <= 1'b1;
    else if (tick)  phase <= ~phase;
  end

  // R5: a tick during a poll flips the phase on the next edge
  assert_tick_flips_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick) |=> (!run || (phase != $past(phase))));

  // R5: without a tick the phase holds
  assert_phase_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> (!run || $stable(phase)));

  // R6: each poll starts with the phase high
  assert_phase_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> phase);

endmodule

// File: rtl/poll_line_select.sv
module poll_line_select (
  input  logic poll_active,
  input  logic busy_local,
  input  logic top_strap,
  input  logic level_mode,
  input  logic upstream_in,
  input  logic phase,
  output logic line_out,
  output logic line_oe
);
  import poll_pkg::*;

  always_comb begin
    line_oe = poll_active;
    if (!poll_active)    line_out = 1'b1;
    else if (busy_local) line_out = 1'b0;
    else                 line_out = idle_value(top_strap, level_mode, upstream_in, phase);
  end

endmodule

// File: rtl/chain_poll_responder.sv
module chain_poll_responder #(
  parameter int unsigned CLK_HZ = 100_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic poll_active,
  input  logic busy_local,
  input  logic top_strap,
  input  logic level_mode,
  input  logic upstream_in,
  output logic sdo_out,
  output logic sdo_oe
);

  logic tick_w;
  logic phase_w;

  poll_prescaler #(.CLK_HZ(CLK_HZ)) u_prescaler (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (poll_active),
    .tick  (tick_w)
  );

  poll_phase u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (poll_active),
    .tick  (tick_w),
    .phase (phase_w)
  );

  poll_line_select u_select (
    .poll_active (poll_active),
    .busy_local  (busy_local),
    .top_strap   (top_strap),
    .level_mode  (level_mode),
    .upstream_in (upstream_in),
    .phase       (phase_w),
    .line_out    (sdo_out),
    .line_oe     (sdo_oe)
  );

  // R2: a busy device pulls the line low
  assert_busy_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_active && busy_local) |-> !sdo_out);

  // R3: an idle device below the top forwards the upstream line
  assert_forward_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_active && !busy_local && !top_strap) |-> (sdo_out == upstream_in));

  // R4: idle top device in level mode holds high (R1 level encoding)
  assert_level_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_active && !busy_local && top_strap && level_mode) |-> sdo_out);

  // R7: outside a poll the line is released
  assert_released_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !poll_active |-> (!sdo_oe && sdo_out));

  // R7: during a poll the line is driven
  assert_driven_R7: assert property (@(posedge clk) disable iff (!rst_n)
    poll_active |-> sdo_oe);

endmodule

// File: tb/test_chain_poll_responder.sv
module test_chain_poll_responder;
  localparam int CLK_PERIOD = 10;
  localparam int unsigned TB_CLK_HZ = 20_000;
  localparam int HALF = TB_CLK_HZ / 2000;   // 10 cycles per half period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic poll = 1'b0;
  logic lvl = 1'b1;
  logic [2:0] busy = 3'b000;    // bit0 top, bit1 middle, bit2 bottom
  logic top_out, top_oe, mid_out, mid_oe, bot_out, bot_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chain_poll_responder #(.CLK_HZ(TB_CLK_HZ)) i_top (
    .clk(clk), .rst_n(rst_n), .poll_active(poll), .busy_local(busy[0]),
    .top_strap(1'b1), .level_mode(lvl), .upstream_in(1'b0),
    .sdo_out(top_out), .sdo_oe(top_oe));

  chain_poll_responder #(.CLK_HZ(TB_CLK_HZ)) i_mid (
    .clk(clk), .rst_n(rst_n), .poll_active(poll), .busy_local(busy[1]),
    .top_strap(1'b0), .level_mode(lvl), .upstream_in(top_out),
    .sdo_out(mid_out), .sdo_oe(mid_oe));

  chain_poll_responder #(.CLK_HZ(TB_CLK_HZ)) i_chain_poll_responder (
    .clk(clk), .rst_n(rst_n), .poll_active(poll), .busy_local(busy[2]),
    .top_strap(1'b0), .level_mode(lvl), .upstream_in(mid_out),
    .sdo_out(bot_out), .sdo_oe(bot_oe));

  task automatic check(input logic act, input logic exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // Square-wave level after n edges since poll start: high in even half periods.
  function automatic logic wave_after(input int n);
    return ((n / HALF) % 2) == 0;
  endfunction

  // Released-state check on all three devices (R7)
  task automatic check_released(input string req);
    check(top_oe, 1'b0, req); check(mid_oe, 1'b0, req); check(bot_oe, 1'b0, req);
    check(top_out, 1'b1, req); check(mid_out, 1'b1, req); check(bot_out, 1'b1, req);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7 reset state: released
    check_released("R7 reset");
    rst_n = 1'b1;
    @(negedge clk);
    busy = 3'b101; lvl = 1'b0;
    @(negedge clk);
    check_released("R7 busy ignored outside poll");

    // R8 / R1 sweep: both modes, every busy pattern; poll ends mid-phase (R6)
    for (int m = 0; m < 2; m++) begin
      for (int mask = 0; mask < 8; mask++) begin
        @(negedge clk);
        poll = 1'b0; lvl = logic'(m); busy = 3'(mask);
        @(negedge clk);
        check_released("R7 between polls");
        poll = 1'b1;
        #1;
        check(bot_oe, 1'b1, "R7 driven in poll");
        for (int n = 0; n <= 2 * HALF + 3; n++) begin
          logic exp_top, exp_mid, exp_bot, src;
          if (n > 0) begin @(posedge clk); #1; end
          src = (m == 1) ? 1'b1 : wave_after(n);
          exp_top = busy[0] ? 1'b0 : src;
          exp_mid = busy[1] ? 1'b0 : exp_top;
          exp_bot = busy[2] ? 1'b0 : exp_mid;
          if (m == 1) check(top_out, exp_top, "R4 level top / R1");
          else        check(top_out, exp_top, "R5 toggle top / R6 restart / R1");
          check(mid_out, exp_mid, "R3 forward / R2 busy");
          check(bot_out, exp_bot, "R8 chain bottom / R2 busy");
        end
      end
    end

    // R3: forwarding tracks upstream combinationally mid-cycle
    @(negedge clk);
    poll = 1'b0; lvl = 1'b0; busy = 3'b000;
    @(negedge clk);
    poll = 1'b1;
    #1;
    check(mid_out, top_out, "R3 same-cycle forward");
    busy[0] = 1'b1;
    #1;
    check(mid_out, 1'b0, "R3 forward low from busy top");
    check(bot_out, 1'b0, "R8 busy top seen at bottom");
    busy[0] = 1'b0;

    // R7: ending poll releases immediately
    @(negedge clk);
    poll = 1'b0;
    #1;
    check_released("R7 poll end");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule